// File: doc/BRIEF.md
# Chained Window Score Accumulator

This block sums per-block linear-classifier contributions into scores for every detection window of a strip, where each window is 5 block-columns wide and 15 block-rows tall. Blocks enter one at a time, top to bottom inside a column and columns left to right. Each accepted block carries one signed contribution for every window that contains it, which is up to 75 windows.

Five chains are instantiated, one for each column offset of the block inside a window. Each chain has 15 stages, one for each row offset. A stage adds the block's contribution to the running score handed down by the stage above on the previous block. It then passes the sum on to the stage below. The score leaving the bottom stage of a chain is parked in a small buffer indexed by the window's top row. The first stage of the next chain picks it up while the following column streams in. A window is final on its 75th block. It is then compared with a signed threshold and reported as pass or reject.

A per-window keep bit travels with each contribution. A zero bit switches off the adding stage for that window from then on, so a window already dropped by an earlier screening pass burns no further additions and always reports reject.

A three-state sequencer controls the flow:
- **IDLE**: waits for `start`.
- **RUN**: accepts blocks on `blk_valid`.
- **DONE**: held for one cycle after the last block of the strip.

The transitions are:
- IDLE to RUN on `start`.
- RUN to DONE when the bottom-right block is accepted.
- DONE to IDLE unconditionally.

Top module: `win_score_chain`

## Requirements
- R1: After reset, `busy`, `frame_done` and `res_valid` are low, and they stay low until `start` is seen in IDLE.
- R2: Blocks presented while IDLE produce no result and do not change any score of the following strip.
- R3: Blocks are taken in column-major order (row 0 first). The result for the window with left column L and top row t is valid exactly one cycle after block (column L+4, row t+14) is accepted, carrying `res_col`=L and `res_row`=t. Results come out in order of increasing L, and increasing t within each L.
- R4: Contribution slot s = j*15+k occupies bits [s*16 +: 16] of `blk_contrib` as a 16-bit signed value. It is the accepted block's contribution to the window whose left column is its own column minus j and whose top row is its own row minus k. The reported `res_score` is the 24-bit signed sum of all 75 contributions of that window.
- R5: If `blk_keep` bit s is 0, the window in slot s is dead. Neither that block nor any later block adds to its score, and the window reports reject. Its score is the sum of the contributions accepted before the kill.
- R6: `res_pass` is 1 only when the window is alive and `res_score` is strictly greater than the signed `thresh`. A score equal to `thresh` is a reject.
- R7: A cycle in RUN with `blk_valid` low advances nothing. The next valid block is treated as the next block in order.
- R8: `frame_done` is high for exactly the one cycle after the last block is accepted, and `busy` is low on the following cycle. A `start` pulse during RUN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a strip when IDLE |
| blk_valid | input | 1 | A block is offered this cycle |
| blk_contrib | input | 1200 | 75 signed 16-bit contributions, slot j*15+k |
| blk_keep | input | 75 | Per-slot keep bit, 0 kills that window |
| thresh | input | 24 | Signed pass threshold |
| busy | output | 1 | Sequencer not in IDLE |
| frame_done | output | 1 | One-cycle end-of-strip pulse |
| res_valid | output | 1 | A finished window is reported |
| res_col | output | 3 | Left block column of reported window |
| res_row | output | 5 | Top block row of reported window |
| res_score | output | 24 | Final signed window score |
| res_pass | output | 1 | Window alive and above threshold |

## Verification
The hardest situation to reach is a window killed by its very last block, where the kill must still turn into a reject. It is just as hard to confirm that the kill blocks the final addition rather than only forcing the flag. The bench reaches it with a strip of all-one contributions in which exactly one slot of block (4,14) is cleared, so window (0,0) must report 74 and reject. Alongside that case, stalls between blocks and a stray `start` during RUN check that parked partial scores survive idle cycles across columns.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/wsa_seq.sv
module wsa_seq
    import wsa_pkg::*;
#(
    parameter int IMG_COLS = 8,
    parameter int IMG_ROWS = 18,
    localparam int RW = $clog2(IMG_ROWS),
    localparam int CLW = $clog2(IMG_COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           blk_valid,
    output logic           step,
    output logic [RW-1:0]  row,
    output logic [CLW-1:0] col,
    output logic           busy,
    output logic           frame_done
);
    seq_state_t state, state_nx;
    logic last_blk;

    assign last_blk = (row == RW'(IMG_ROWS - 1)) && (col == CLW'(IMG_COLS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_RUN;
            S_RUN:  if (blk_valid && last_blk) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        step       = (state == S_RUN) && blk_valid;
        busy       = (state != S_IDLE);
        frame_done = (state == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (step) begin
            if (row == RW'(IMG_ROWS - 1)) begin
                row <= '0;
                col <= last_blk ? '0 : col + 1'b1;
            end else begin
                row <= row + 1'b1;
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> (state == S_IDLE));
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !blk_valid) |=> ($stable(row) && $stable(col)));
    // R3
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(row) < IMG_ROWS));
endmodule

// File: rtl/wsa_chain.sv
module wsa_chain #(
    parameter int ROWS = 15,
    parameter int CW = 16,
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic signed [SW-1:0] seed_score,
    input  logic                 seed_dead,
    input  logic [ROWS*CW-1:0]   contrib,
    input  logic [ROWS-1:0]      keep,
    output logic signed [SW-1:0] tail_score,
    output logic                 tail_dead
);
    logic signed [SW-1:0] acc   [ROWS];
    logic                 dead  [ROWS];
    logic signed [SW-1:0] in_s  [ROWS];
    logic                 in_d  [ROWS];
    logic signed [SW-1:0] nxt_s [ROWS];
    logic                 nxt_d [ROWS];

    always_comb begin
        logic signed [SW-1:0] ext;
        in_s[0] = seed_score;
        in_d[0] = seed_dead;
        for (int k = 1; k < ROWS; k++) begin
            in_s[k] = acc[k-1];
            in_d[k] = dead[k-1];
        end
        for (int k = 0; k < ROWS; k++) begin
            ext = {{(SW-CW){contrib[k*CW+CW-1]}}, contrib[k*CW +: CW]};
            nxt_d[k] = in_d[k] | ~keep[k];
            nxt_s[k] = (keep[k] && !in_d[k]) ? in_s[k] + ext : in_s[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ROWS; k++) begin
                acc[k]  <= '0;
                dead[k] <= 1'b0;
            end
        end else if (step) begin
            for (int k = 0; k < ROWS; k++) begin
                acc[k]  <= nxt_s[k];
                dead[k] <= nxt_d[k];
            end
        end
    end

    assign tail_score = nxt_s[ROWS-1];
    assign tail_dead  = nxt_d[ROWS-1];

    // R5
    gated_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !keep[0]) |=> (acc[0] == $past(seed_score) && dead[0]));
endmodule

// File: rtl/wsa_park.sv
module wsa_park #(
    parameter int DEPTH = 4,
    parameter int SW = 24,
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [SW-1:0] wr_score,
    input  logic                 wr_dead,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [SW-1:0] rd_score,
    output logic                 rd_dead
);
    logic signed [SW-1:0] mem_s [DEPTH];
    logic                 mem_d [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_s[i] <= '0;
                mem_d[i] <= 1'b0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IW'(i)) begin
                    mem_s[i] <= wr_score;
                    mem_d[i] <= wr_dead;
                end
            end
        end
    end

    always_comb begin
        rd_score = '0;
        rd_dead  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_score = mem_s[i];
                rd_dead  = mem_d[i];
            end
        end
    end
endmodule

// File: rtl/win_score_chain.sv
module win_score_chain #(
    parameter int WIN_COLS = 5,
    parameter int WIN_ROWS = 15,
    parameter int IMG_COLS = 8,
    parameter int IMG_ROWS = 18,
    parameter int CW = 16,
    parameter int SW = 24,
    localparam int NSLOT = WIN_COLS * WIN_ROWS,
    localparam int TOPS = IMG_ROWS - WIN_ROWS + 1,
    localparam int RW = $clog2(IMG_ROWS),
    localparam int CLW = $clog2(IMG_COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 blk_valid,
    input  logic [NSLOT*CW-1:0]  blk_contrib,
    input  logic [NSLOT-1:0]     blk_keep,
    input  logic signed [SW-1:0] thresh,
    output logic                 busy,
    output logic                 frame_done,
    output logic                 res_valid,
    output logic [CLW-1:0]       res_col,
    output logic [RW-1:0]        res_row,
    output logic signed [SW-1:0] res_score,
    output logic                 res_pass
);
    logic           step;
    logic [RW-1:0]  row;
    logic [CLW-1:0] col;
    logic           emit, park_wr;
    logic [RW-1:0]  park_idx;

    logic signed [SW-1:0] seed_s [WIN_COLS];
    logic                 seed_d [WIN_COLS];
    logic signed [SW-1:0] tail_s [WIN_COLS];
    logic                 tail_d [WIN_COLS];

    wsa_seq #(.IMG_COLS(IMG_COLS), .IMG_ROWS(IMG_ROWS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
        .step(step), .row(row), .col(col), .busy(busy), .frame_done(frame_done)
    );

    assign park_wr  = step && (row >= RW'(WIN_ROWS - 1));
    assign park_idx = row - RW'(WIN_ROWS - 1);
    assign emit     = park_wr && (col >= CLW'(WIN_COLS - 1));

    assign seed_s[0] = '0;
    assign seed_d[0] = 1'b0;

    for (genvar j = 0; j < WIN_COLS; j++) begin : g_col
        wsa_chain #(.ROWS(WIN_ROWS), .CW(CW), .SW(SW)) u_chain (
            .clk(clk), .rst_n(rst_n), .step(step),
            .seed_score(seed_s[j]), .seed_dead(seed_d[j]),
            .contrib(blk_contrib[j*WIN_ROWS*CW +: WIN_ROWS*CW]),
            .keep(blk_keep[j*WIN_ROWS +: WIN_ROWS]),
            .tail_score(tail_s[j]), .tail_dead(tail_d[j])
        );
        if (j < WIN_COLS - 1) begin : g_park
            wsa_park #(.DEPTH(TOPS), .SW(SW), .IW(RW)) u_park (
                .clk(clk), .rst_n(rst_n), .wr_en(park_wr), .wr_idx(park_idx),
                .wr_score(tail_s[j]), .wr_dead(tail_d[j]), .rd_idx(row),
                .rd_score(seed_s[j+1]), .rd_dead(seed_d[j+1])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_col   <= '0;
            res_row   <= '0;
            res_score <= '0;
            res_pass  <= 1'b0;
        end else begin
            res_valid <= emit;
            if (emit) begin
                res_col   <= col - CLW'(WIN_COLS - 1);
                res_row   <= park_idx;
                res_score <= tail_s[WIN_COLS-1];
                res_pass  <= !tail_d[WIN_COLS-1] && (tail_s[WIN_COLS-1] > thresh);
            end
        end
    end

    // R6
    pass_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass) |-> (res_score > $past(thresh)));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !res_valid);
endmodule

// File: tb/tb_win_score_chain.sv
module tb_win_score_chain;
    localparam int WC = 5, WR = 15, IC = 8, IR = 18, CW = 16, SW = 24;
    localparam int NS = WC * WR;
    localparam int TOPS = IR - WR + 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, blk_valid = 1'b0;
    logic [NS*CW-1:0] blk_contrib = '0;
    logic [NS-1:0] blk_keep = '0;
    logic signed [SW-1:0] thresh = '0;
    logic busy, frame_done, res_valid, res_pass;
    logic [2:0] res_col;
    logic [4:0] res_row;
    logic signed [SW-1:0] res_score;

    win_score_chain dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
        .blk_contrib(blk_contrib), .blk_keep(blk_keep), .thresh(thresh),
        .busy(busy), .frame_done(frame_done), .res_valid(res_valid),
        .res_col(res_col), .res_row(res_row), .res_score(res_score), .res_pass(res_pass)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, done_due = -1;
    int cb [IC][IR][NS];
    bit kp [IC][IR][NS];
    int exp_s [IC][TOPS];
    bit exp_p [IC][TOPS];
    int q_due[$], q_col[$], q_row[$], q_sc[$], q_ps[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            chk(res_valid == 1'b1, "R3 result valid", int'(res_valid), 1);
            chk(int'(res_col) == q_col[0], "R3 result column", int'(res_col), q_col[0]);
            chk(int'(res_row) == q_row[0], "R3 result row", int'(res_row), q_row[0]);
            chk(int'(res_score) == q_sc[0], "R4/R5 score", int'(res_score), q_sc[0]);
            chk(int'(res_pass) == q_ps[0], "R5/R6 pass flag", int'(res_pass), q_ps[0]);
            void'(q_due.pop_front()); void'(q_col.pop_front()); void'(q_row.pop_front());
            void'(q_sc.pop_front()); void'(q_ps.pop_front());
        end else if (res_valid) begin
            chk(1'b0, "R2/R3 unexpected result", 1, 0);
        end
        if (done_due >= 0) begin
            chk(frame_done == (cyc == done_due), "R8 done pulse", int'(frame_done),
                int'(cyc == done_due));
            if (cyc == done_due + 1) chk(busy == 1'b0, "R8 idle after done", int'(busy), 0);
        end
    endtask

    // mode 0 random, 1 ones, 2 random with kills, 3 negative
    task automatic gen_frame(input int mode);
        for (int c = 0; c < IC; c++)
            for (int r = 0; r < IR; r++)
                for (int s = 0; s < NS; s++) begin
                    case (mode)
                        0, 2: cb[c][r][s] = int'($urandom % 65536) - 32768;
                        1: cb[c][r][s] = 1;
                        default: cb[c][r][s] = -int'($urandom % 2000);
                    endcase
                    kp[c][r][s] = (mode == 2) ? (($urandom % 150) != 0) : 1'b1;
                end
    endtask

    task automatic model(input int th);
        for (int l = 0; l + WC <= IC; l++)
            for (int t = 0; t < TOPS; t++) begin
                int s = 0;
                bit alive = 1'b1;
                for (int j = 0; j < WC; j++)
                    for (int k = 0; k < WR; k++) begin
                        if (alive && kp[l+j][t+k][j*WR+k]) s += cb[l+j][t+k][j*WR+k];
                        else alive = 1'b0;
                    end
                exp_s[l][t] = s;
                exp_p[l][t] = alive && (s > th);
            end
    endtask

    task automatic run_frame(input int th, input bit gaps, input bit stray_start);
        thresh = th;
        model(th);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        for (int c = 0; c < IC; c++)
            for (int r = 0; r < IR; r++) begin
                if (gaps && ($urandom % 3 == 0)) begin
                    blk_valid = 1'b0;
                    blk_contrib = {NS*CW{1'b1}};
                    tick();
                end
                blk_valid = 1'b1;
                start = stray_start && (c == 3) && (r == 2);
                for (int s = 0; s < NS; s++) begin
                    blk_contrib[s*CW +: CW] = cb[c][r][s][CW-1:0];
                    blk_keep[s] = kp[c][r][s];
                end
                if (c >= WC - 1 && r >= WR - 1) begin
                    q_due.push_back(cyc + 1); q_col.push_back(c - WC + 1);
                    q_row.push_back(r - WR + 1); q_sc.push_back(exp_s[c-WC+1][r-WR+1]);
                    q_ps.push_back(int'(exp_p[c-WC+1][r-WR+1]));
                end
                if (c == IC - 1 && r == IR - 1) done_due = cyc + 1;
                tick();
                start = 1'b0;
            end
        blk_valid = 1'b0;
        tick();
        tick();
        chk(q_due.size() == 0, "R3 all windows reported", q_due.size(), 0);
        done_due = -1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(frame_done == 1'b0, "R1 reset done", int'(frame_done), 0);
        chk(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
        // R2: garbage blocks while idle
        for (int i = 0; i < 6; i++) begin
            blk_valid = 1'b1;
            blk_keep = '1;
            for (int s = 0; s < NS; s++) blk_contrib[s*CW +: CW] = 16'h4321;
            tick();
        end
        blk_valid = 1'b0;
        tick();
        chk(busy == 1'b0, "R2 still idle", int'(busy), 0);
        // R4 random contributions
        gen_frame(0);
        run_frame(0, 1'b0, 1'b0);
        // R7 stalls, R8 stray start, R5 random kills
        gen_frame(2);
        run_frame(-5000, 1'b1, 1'b1);
        // R6 equality boundary: every alive score is 75
        gen_frame(1);
        run_frame(75, 1'b0, 1'b0);
        // R6 just below, R5 kill on window (0,0) last block
        gen_frame(1);
        kp[4][14][4*WR+14] = 1'b0;
        run_frame(74, 1'b1, 1'b0);
        chk(exp_s[0][0] == 74 && exp_p[0][0] == 1'b0, "R5 model last-block kill",
            exp_s[0][0], 74);
        // R4/R6 negative scores and threshold
        gen_frame(3);
        run_frame(-75000, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule